// File: doc/BRIEF.md
# Subroutine Frame Builder and Unwinder

This block is the multi-cycle part of a processor core that performs subroutine entry and exit. It runs on a machine where register 0 holds the frame pointer and register 1 holds the stack pointer. The decoder pulses `start_i` with an operation code, the address of the instruction being executed, the call target and the current pointer values. The block then makes exactly two word accesses through a single 32-bit memory port. When it finishes, it presents the new frame pointer, stack pointer and program counter, together with a one-cycle `done_o` pulse.

Every call-type operation makes a three-word frame below the old stack pointer. The highest word is left unwritten as a static-chain slot. The middle word receives the return address. The lowest word receives the caller's frame pointer, and both pointers end up pointing at that lowest word. A return finds the frame through the frame pointer, not the stack pointer. It reloads the saved frame pointer and the return PC, then sets the stack pointer past all three words.

A software-trap operation builds the same frame as a call. It then jumps to a handler address supplied on `trap_vec_i` from a configuration register outside the block.

Top module: `frame_seq`

## Requirements
- R1: After reset, `fp_o`, `sp_o` and `pc_o` read zero, and `mem_req_o` and `done_o` are low.
- R2: A call-type operation (op 0, 1 or 3) makes two writes (`mem_we_o`=1) in a fixed order. The first writes the return address at old SP-8. The second writes the old FP at old SP-12. The slot at old SP-4 is never accessed.
- R3: The op code sets the return address. Op 0 is a call with an absolute target and saves PC+6. Op 1 is a call through a register and saves PC+2. Op 3 is a trap and saves PC+6. Op 2 is the return.
- R4: After a call (op 0 or 1), `fp_o` and `sp_o` both equal old SP-12, and `pc_o` equals `target_i`.
- R5: A return (op 2) makes two reads (`mem_we_o`=0), first at FP and then at FP+4. It ends with `fp_o` equal to the first word read, `pc_o` equal to the second word read, and `sp_o` equal to FP+12.
- R6: A trap (op 3) ends with `fp_o` and `sp_o` equal to old SP-12 and `pc_o` equal to `trap_vec_i`.
- R7: Each access keeps `mem_req_o`, the address, the write enable and the write data steady until `mem_ready_i` is seen. The second access is requested in the cycle right after the first is accepted.
- R8: `done_o` is high for exactly one cycle, the cycle after the second access is accepted. `fp_o`, `sp_o` and `pc_o` change only in that cycle.
- R9: A `start_i` pulse that arrives while a sequence is in progress, or in its done cycle, is ignored. It does not change the running sequence and does not start a new one.
- R10: `mem_addr_o` always has its two low bits cleared, whatever the alignment of the pointer values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only when idle |
| op_i | input | 2 | 0 call absolute, 1 call register, 2 return, 3 trap |
| pc_i | input | 32 | Address of the instruction being executed |
| target_i | input | 32 | Call target |
| trap_vec_i | input | 32 | Trap handler address |
| fp_i | input | 32 | Current frame pointer |
| sp_i | input | 32 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access accepted |
| fp_o | output | 32 | Updated frame pointer |
| sp_o | output | 32 | Updated stack pointer |
| pc_o | output | 32 | Updated program counter |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The bench runs all four op codes, and crosses each one with several pointer pairs and memory wait latencies of zero, one and two cycles. Pointers that are aligned, unaligned and close to the top and bottom of the address space separate correct frame arithmetic from truncated or wrong-signed offsets. They also show that address alignment does not touch the returned stack pointer. The different waits separate a held request from one that moves early, and a correct back-to-back second access from one that arrives late. Read data is a fixed function of the address, so a swapped read order or a swapped result assignment shows up as a wrong value. Start pulses and changing pointer inputs during long waits show whether inputs are latched once at the start.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_RET      = 2'd2,
    OP_TRAP     = 2'd3
  } fseq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_FIN  = 2'd3
  } fseq_state_e;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic load_o,
  output logic req_o,
  output logic step_o,
  output logic first_acc_o,
  output logic last_acc_o,
  output logic done_o
);
  fseq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC0;
      ST_ACC0: if (ready_i) state_d = ST_ACC1;
      ST_ACC1: if (ready_i) state_d = ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign req_o       = (state_q == ST_ACC0) || (state_q == ST_ACC1);
  assign step_o      = (state_q == ST_ACC1);
  assign first_acc_o = (state_q == ST_ACC0) && ready_i;
  assign last_acc_o  = (state_q == ST_ACC1) && ready_i;
  assign done_o      = (state_q == ST_FIN);
endmodule

// File: rtl/fseq_addr_gen.sv
module fseq_addr_gen
  import fseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  fseq_op_e        op_i,
  input  logic            step_i,
  input  logic [DW-1:0]   fp_i,
  input  logic [DW-1:0]   sp_i,
  input  logic [DW-1:0]   ret_addr_i,
  output logic            we_o,
  output logic [DW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o
);
  localparam int WB = DW / 8;
  localparam int LSB = $clog2(WB);
  localparam logic [DW-1:0] OFS_RA = DW'(2 * WB);
  localparam logic [DW-1:0] OFS_FP = DW'(3 * WB);
  localparam logic [DW-1:0] OFS_W  = DW'(WB);

  logic [DW-1:0] raw_addr;

  always_comb begin
    if (op_i == OP_RET) begin
      we_o     = 1'b0;
      raw_addr = step_i ? fp_i + OFS_W : fp_i;
      wdata_o  = '0;
    end else begin
      we_o     = 1'b1;
      raw_addr = step_i ? sp_i - OFS_FP : sp_i - OFS_RA;
      wdata_o  = step_i ? fp_i : ret_addr_i;
    end
  end

  assign addr_o = {raw_addr[DW-1:LSB], {LSB{1'b0}}};
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import fseq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  input  logic [DW-1:0] trap_vec_i,
  input  logic [DW-1:0] fp_i,
  input  logic [DW-1:0] sp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] pc_o,
  output logic          done_o
);
  localparam int WB = DW / 8;
  localparam logic [DW-1:0] LEN_LONG  = DW'(6);
  localparam logic [DW-1:0] LEN_SHORT = DW'(2);
  localparam logic [DW-1:0] FRAME     = DW'(3 * WB);

  fseq_op_e      op_q;
  logic [DW-1:0] fp_q, sp_q, ret_q, tgt_q, rd0_q;
  logic          load, step, first_acc, last_acc;

  fseq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ready_i     (mem_ready_i),
    .load_o      (load),
    .req_o       (mem_req_o),
    .step_o      (step),
    .first_acc_o (first_acc),
    .last_acc_o  (last_acc),
    .done_o      (done_o)
  );

  fseq_addr_gen #(.DW(DW)) u_addr (
    .op_i       (op_q),
    .step_i     (step),
    .fp_i       (fp_q),
    .sp_i       (sp_q),
    .ret_addr_i (ret_q),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );

  // Operands are latched once, so input changes while busy have no effect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_CALL_ABS;
      fp_q  <= '0;
      sp_q  <= '0;
      ret_q <= '0;
      tgt_q <= '0;
    end else if (load) begin
      op_q  <= fseq_op_e'(op_i);
      fp_q  <= fp_i;
      sp_q  <= sp_i;
      ret_q <= pc_i + ((fseq_op_e'(op_i) == OP_CALL_REG) ? LEN_SHORT : LEN_LONG);
      tgt_q <= (fseq_op_e'(op_i) == OP_TRAP) ? trap_vec_i : target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd0_q <= '0;
    else if (first_acc) rd0_q <= mem_rdata_i;
  end

  // Architectural results commit on the edge that raises done_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_o <= '0;
      sp_o <= '0;
      pc_o <= '0;
    end else if (last_acc) begin
      if (op_q == OP_RET) begin
        fp_o <= rd0_q;
        pc_o <= mem_rdata_i;
        sp_o <= fp_q + FRAME;
      end else begin
        fp_o <= sp_q - FRAME;
        sp_o <= sp_q - FRAME;
        pc_o <= tgt_q;
      end
    end
  end
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic [DW-1:0] fp_o,
  input logic [DW-1:0] sp_o,
  input logic [DW-1:0] pc_o,
  input logic          done_o
);
  p_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_acc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_ready_i));

  p_arch_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fp_o) && $stable(sp_o) && $stable(pc_o)));

  p_no_req_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);
endmodule

bind frame_seq fseq_chk #(.DW(DW)) u_fseq_chk (.*);

// File: tb/frame_seq_tb_top.sv
`timescale 1ns/1ps
module frame_seq_tb_top;
  localparam logic [31:0] K = 32'hC3C3_5A00;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] pc_i = '0, target_i = '0, trap_vec_i = '0, fp_i = '0, sp_i = '0;
  logic        mem_req_o, mem_we_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, fp_o, sp_o, pc_o;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  frame_seq dut_i (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [31:0] pc, input logic [31:0] tgt,
                        input logic [31:0] vec, input logic [31:0] fp,
                        input logic [31:0] sp, input int lat, input bit disturb);
    logic [31:0] a [2];
    logic [31:0] w [2];
    logic [31:0] fp_e, sp_e, pc_e, ret_e, fp_p, sp_p, pc_p;
    bit we_e;
    ret_e = (op == 1) ? pc + 32'd2 : pc + 32'd6;
    if (op == 2) begin
      we_e = 1'b0;
      a[0] = fp & ~32'd3;
      a[1] = (fp & ~32'd3) + 32'd4;
      w[0] = '0; w[1] = '0;
      fp_e = a[0] ^ K;
      pc_e = a[1] ^ K;
      sp_e = fp + 32'd12;
    end else begin
      we_e = 1'b1;
      a[0] = (sp - 32'd8) & ~32'd3;
      a[1] = (sp - 32'd12) & ~32'd3;
      w[0] = ret_e; w[1] = fp;
      fp_e = sp - 32'd12;
      sp_e = sp - 32'd12;
      pc_e = (op == 3) ? vec : tgt;
    end
    fp_p = fp_o; sp_p = sp_o; pc_p = pc_o;

    @(negedge clk_i);
    op_i = 2'(op); pc_i = pc; target_i = tgt; trap_vec_i = vec;
    fp_i = fp; sp_i = sp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check(mem_req_o == 1'b1, "R7 back-to-back request", 32'(mem_req_o), 32'd1);
      for (int l = 0; l < lat; l++) begin
        if (disturb) begin
          start_i = 1'b1; op_i = ~op_i; fp_i = ~fp_i; sp_i = sp_i + 32'd64;
        end
        @(negedge clk_i);
        check(mem_req_o == 1'b1, "R7 request held", 32'(mem_req_o), 32'd1);
      end
      start_i = 1'b0;
      check(mem_addr_o == a[k], (op == 2) ? "R5 read address" : "R2 write address",
            mem_addr_o, a[k]);
      check(mem_addr_o != ((sp - 32'd4) & ~32'd3) || op == 2, "R2 static slot untouched",
            mem_addr_o, (sp - 32'd4));
      check(mem_addr_o[1:0] == 2'b00, "R10 aligned address", mem_addr_o, a[k]);
      check(mem_we_o == we_e, (op == 2) ? "R5 read strobe" : "R2 write strobe",
            32'(mem_we_o), 32'(we_e));
      if (we_e)
        check(mem_wdata_o == w[k], (k == 0) ? "R3 return address data" : "R2 saved fp data",
              mem_wdata_o, w[k]);
      check(done_o == 1'b0 && fp_o == fp_p && sp_o == sp_p && pc_o == pc_p,
            "R8 outputs held while busy", fp_o, fp_p);
      mem_ready_i = 1'b1;
      mem_rdata_i = mem_addr_o ^ K;
      @(negedge clk_i);
      mem_ready_i = 1'b0;
      mem_rdata_i = '0;
    end
    check(done_o == 1'b1, "R8 done after last access", 32'(done_o), 32'd1);
    check(mem_req_o == 1'b0, "R8 no request in done cycle", 32'(mem_req_o), 32'd0);
    check(fp_o == fp_e, (op == 2) ? "R5 fp" : (op == 3) ? "R6 fp" : "R4 fp", fp_o, fp_e);
    check(sp_o == sp_e, (op == 2) ? "R5 sp" : (op == 3) ? "R6 sp" : "R4 sp", sp_o, sp_e);
    check(pc_o == pc_e, (op == 2) ? "R5 pc" : (op == 3) ? "R6 pc" : "R4 pc", pc_o, pc_e);
    if (disturb) start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b0, "R8 done single cycle", 32'(done_o), 32'd0);
    check(mem_req_o == 1'b0, "R9 start during done ignored", 32'(mem_req_o), 32'd0);
    check(fp_o == fp_e && sp_o == sp_e && pc_o == pc_e, "R8 outputs stable after done",
          pc_o, pc_e);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sps [4];
    logic [31:0] fps [4];
    sps[0] = 32'h0000_1000; fps[0] = 32'h0000_0FF0;
    sps[1] = 32'h0000_2003; fps[1] = 32'h0000_3001;
    sps[2] = 32'h0000_0008; fps[2] = 32'hFFFF_FFFE;
    sps[3] = 32'hFFFF_FFF0; fps[3] = 32'h8000_0000;
    repeat (3) @(negedge clk_i);
    check(fp_o == 0 && sp_o == 0 && pc_o == 0, "R1 reset pointers", fp_o | sp_o | pc_o, 0);
    check(mem_req_o == 0 && done_o == 0, "R1 reset strobes", 32'({mem_req_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(mem_req_o == 0 && done_o == 0, "R1 idle after reset", 32'({mem_req_o, done_o}), 0);
    for (int op = 0; op < 4; op++)
      for (int s = 0; s < 4; s++)
        for (int lat = 0; lat < 3; lat++)
          run_op(op, 32'h0000_0400 + 32'(s * 16 + op * 2), 32'h0001_0000 + 32'(s * 256),
                 32'h0002_0000 + 32'(op * 4 + s * 8), fps[s], sps[s], lat, lat == 2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule